// File: doc/BRIEF.md
# Framed Serial Register Slave

This block lets a host program a peripheral over four wires: an active-low select, a serial clock, a command data line into the block, and a reply data line out of it. Each transfer opens when the select goes low. The host then sends an address byte and, depending on that address, sends zero, one or two data bytes or receives one or two reply bytes. Every field travels most significant bit first. All serial inputs are brought into the block's own clock domain, so the serial clock must run several times slower than `clk`. The serial clock idles low.

The address selects the kind of access. Some addresses take a full 16-bit word and some take a single byte. One address is a command with no data that returns every register to its reset value. Other addresses read back a register or a live status word. Writes land only when the select rises after exactly the expected number of bits. Any shorter or longer frame is discarded. A pad driver built from `reply_oe` and `reply_o` gives a line that floats whenever no reply bit is being driven. One control word also drives two output-inversion flags that are decoded straight from it.

Top module: `serctl_slave`

## Requirements
- R1: The bits of a frame are taken on rising serial clock edges, most significant bit first. A frame at address 0x80+i (i = 0..3) followed by 16 data bits stores the data in word register i, which appears on `words_o[16*i +: 16]`.
- R2: A frame at address 0x10+i (i = 0..1) followed by 8 data bits stores the byte in byte register i, which appears on `bytes_o[8*i +: 8]`.
- R3: A register changes only when the select rises after exactly 8 + N bits, where N is the data length of the address. A frame cut short, or one carrying extra bits, leaves every register unchanged.
- R4: Address 0x01 framed with no data bits clears every word and byte register to 0 when the select rises. The same address followed by data bits has no effect.
- R5: Address 0xC0+i returns word register i as 16 reply bits, most significant first. The first bit is driven after the 8th falling serial clock edge, and each later bit after the next falling edge.
- R6: Address 0x18+i returns byte register i as 8 reply bits, most significant first, with the same timing as R5.
- R7: Address 0x94 returns `status_i` as 16 bits, sampled at the 8th rising edge. A change on `status_i` after that edge does not appear in the reply.
- R8: `reply_oe` is high only while a reply bit is on the line. It falls at the falling edge that follows the last reply bit, and it is low whenever the select is high.
- R9: `inv_a_o` equals bit 7 of word register 2 and `inv_b_o` equals bit 15 of that register. Each flag follows its own bit alone.
- R10: A frame at any other address changes no register and drives no reply.
- R11: After reset all registers are 0, both inversion flags are 0 and `reply_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idles low |
| cmd_in | input | 1 | Serial command and data from the host |
| status_i | input | 16 | Live status word read at address 0x94 |
| reply_o | output | 1 | Serial reply bit |
| reply_oe | output | 1 | Drive enable for the reply pad |
| words_o | output | 64 | Four 16-bit word registers, register i in bits 16*i+15..16*i |
| bytes_o | output | 16 | Two byte registers, register i in bits 8*i+7..8*i |
| inv_a_o | output | 1 | Inversion select for channel A |
| inv_b_o | output | 1 | Inversion select for channel B |

## Verification
A table of write-then-read-back pairs covers both word widths with patterns of alternating bits, single set bits at either end and mixed bytes. These patterns catch bit-order reversal, off-by-one shifting and a wrong register index. Directed frames then use the wrong bit count in both directions, the reset command with and without trailing data, and an unmapped address. These show whether commits depend on the exact length. A status read whose input changes in the middle of the reply shows whether the value is captured at the end of the address byte. A read clocked one bit past its end shows when the drive enable drops.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

  // Access classes produced by the address decoder.
  typedef enum logic [2:0] {
    AK_NONE  = 3'd0,
    AK_RESET = 3'd1,
    AK_WR8   = 3'd2,
    AK_WR16  = 3'd3,
    AK_RD8   = 3'd4,
    AK_RD16  = 3'd5,
    AK_STAT  = 3'd6
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [7:0] idx;
  } acc_dec_t;

  // Number of bits after the address byte for each class.
  function automatic logic [4:0] payload_bits(acc_kind_e k);
    case (k)
      AK_WR16, AK_RD16, AK_STAT: return 5'd16;
      AK_WR8,  AK_RD8:           return 5'd8;
      default:                   return 5'd0;
    endcase
  endfunction

  function automatic logic is_read(acc_kind_e k);
    return (k == AK_RD8) || (k == AK_RD16) || (k == AK_STAT);
  endfunction

  function automatic logic is_commit(acc_kind_e k);
    return (k == AK_WR8) || (k == AK_WR16) || (k == AK_RESET);
  endfunction

  // Total frame length, address included.
  function automatic logic [5:0] frame_bits(acc_kind_e k);
    return 6'd8 + {1'b0, payload_bits(k)};
  endfunction

endpackage

// File: rtl/serctl_pin_sync.sv
module serctl_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic cmd_in,
  output logic cs_act,
  output logic cs_end,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cmd_s
);
  // Bit order in each stage: {cs_n, sclk, cmd}
  localparam logic [2:0] IDLE_PINS = 3'b100;

  logic [2:0] stage_q [STAGES];
  logic       sclk_prev_q;
  logic       act_prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= IDLE_PINS;
        end else if (s == 0) begin
          stage_q[s] <= {cs_n, sclk, cmd_in};
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      act_prev_q  <= 1'b0;
    end else begin
      sclk_prev_q <= stage_q[STAGES-1][1];
      act_prev_q  <= cs_act;
    end
  end

  assign cs_act    = ~stage_q[STAGES-1][2];
  assign cmd_s     = stage_q[STAGES-1][0];
  assign cs_end    = act_prev_q & ~cs_act;
  assign sclk_rise = cs_act &  stage_q[STAGES-1][1] & ~sclk_prev_q;
  assign sclk_fall = cs_act & ~stage_q[STAGES-1][1] &  sclk_prev_q;

endmodule

// File: rtl/serctl_addr_decode.sv
module serctl_addr_decode
  import serctl_pkg::*;
#(
  parameter int RESET_ADDR   = 8'h01,
  parameter int BYTE_BASE    = 8'h10,
  parameter int BYTE_RD_BASE = 8'h18,
  parameter int BYTE_COUNT   = 2,
  parameter int WORD_BASE    = 8'h80,
  parameter int WORD_RD_BASE = 8'hC0,
  parameter int WORD_COUNT   = 4,
  parameter int STATUS_ADDR  = 8'h94
) (
  input  logic [7:0] addr,
  output acc_dec_t   dec
);
  function automatic logic in_window(logic [7:0] a, int base, int cnt);
    return (int'(a) >= base) && (int'(a) < base + cnt);
  endfunction

  function automatic logic [7:0] offset(logic [7:0] a, int base);
    return 8'(int'(a) - base);
  endfunction

  always_comb begin
    dec = '{kind: AK_NONE, idx: 8'h00};
    if (int'(addr) == RESET_ADDR) begin
      dec.kind = AK_RESET;
    end else if (int'(addr) == STATUS_ADDR) begin
      dec.kind = AK_STAT;
    end else if (in_window(addr, WORD_BASE, WORD_COUNT)) begin
      dec.kind = AK_WR16;
      dec.idx  = offset(addr, WORD_BASE);
    end else if (in_window(addr, WORD_RD_BASE, WORD_COUNT)) begin
      dec.kind = AK_RD16;
      dec.idx  = offset(addr, WORD_RD_BASE);
    end else if (in_window(addr, BYTE_BASE, BYTE_COUNT)) begin
      dec.kind = AK_WR8;
      dec.idx  = offset(addr, BYTE_BASE);
    end else if (in_window(addr, BYTE_RD_BASE, BYTE_COUNT)) begin
      dec.kind = AK_RD8;
      dec.idx  = offset(addr, BYTE_RD_BASE);
    end
  end

endmodule

// File: rtl/serctl_frame_engine.sv
module serctl_frame_engine
  import serctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_act,
  input  logic        cs_end,
  input  logic        sclk_rise,
  input  logic        sclk_fall,
  input  logic        cmd_s,
  output logic [7:0]  addr_next,
  input  acc_dec_t    dec,
  input  logic [15:0] rd_val,
  output logic        wr16_pulse,
  output logic        wr8_pulse,
  output logic        clr_pulse,
  output logic [7:0]  wr_idx,
  output logic [15:0] wr_data,
  output logic        reply_bit,
  output logic        reply_oe
);
  localparam logic [5:0] CNT_MAX = 6'h3F;

  logic [5:0]  bit_cnt_q;
  logic [7:0]  addr_sr_q;
  logic [15:0] data_sr_q;
  logic [15:0] tx_sr_q;
  logic [4:0]  tx_cnt_q;
  logic        addr_done_q;
  acc_kind_e   kind_q;
  logic [7:0]  idx_q;

  // Named internal events
  logic addr_last_bit;
  logic frame_exact;
  logic commit_evt;
  logic tx_more;

  assign addr_next     = {addr_sr_q[6:0], cmd_s};
  assign addr_last_bit = sclk_rise & ~addr_done_q & (bit_cnt_q == 6'd7);
  assign frame_exact   = addr_done_q & (bit_cnt_q == frame_bits(kind_q));
  assign commit_evt    = cs_end & frame_exact & is_commit(kind_q);
  assign tx_more       = addr_done_q & is_read(kind_q) & (tx_cnt_q < payload_bits(kind_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q   <= '0;
      addr_sr_q   <= '0;
      data_sr_q   <= '0;
      tx_sr_q     <= '0;
      tx_cnt_q    <= '0;
      addr_done_q <= 1'b0;
      kind_q      <= AK_NONE;
      idx_q       <= '0;
      reply_bit   <= 1'b0;
      reply_oe    <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt_q   <= '0;
      tx_cnt_q    <= '0;
      addr_done_q <= 1'b0;
      kind_q      <= AK_NONE;
      reply_oe    <= 1'b0;
    end else begin
      if (sclk_rise) begin
        if (bit_cnt_q != CNT_MAX) bit_cnt_q <= bit_cnt_q + 6'd1;
        if (!addr_done_q) begin
          addr_sr_q <= addr_next;
        end else begin
          data_sr_q <= {data_sr_q[14:0], cmd_s};
        end
      end
      if (addr_last_bit) begin
        addr_done_q <= 1'b1;
        kind_q      <= dec.kind;
        idx_q       <= dec.idx;
        tx_sr_q     <= rd_val;
      end
      if (sclk_fall) begin
        if (tx_more) begin
          reply_bit <= tx_sr_q[15];
          tx_sr_q   <= {tx_sr_q[14:0], 1'b0};
          tx_cnt_q  <= tx_cnt_q + 5'd1;
          reply_oe  <= 1'b1;
        end else begin
          reply_oe  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr16_pulse <= 1'b0;
      wr8_pulse  <= 1'b0;
      clr_pulse  <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
    end else begin
      wr16_pulse <= commit_evt & (kind_q == AK_WR16);
      wr8_pulse  <= commit_evt & (kind_q == AK_WR8);
      clr_pulse  <= commit_evt & (kind_q == AK_RESET);
      if (commit_evt) begin
        wr_idx  <= idx_q;
        wr_data <= data_sr_q;
      end
    end
  end

  // R8: once the select is seen high, the pad is released on the next cycle
  assert_oe_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !reply_oe);

  // R5: the reply bit only moves in the cycle after a falling serial edge
  assert_bit_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sclk_fall) |-> $stable(reply_bit));

  // R3: at most one kind of commit pulse per cycle
  assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr16_pulse, wr8_pulse, clr_pulse}) <= 1);

endmodule

// File: rtl/serctl_regbank.sv
module serctl_regbank
  import serctl_pkg::*;
#(
  parameter int WORD_COUNT = 4,
  parameter int BYTE_COUNT = 2,
  parameter int INV_IDX    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr16_pulse,
  input  logic                      wr8_pulse,
  input  logic                      clr_pulse,
  input  logic [7:0]                wr_idx,
  input  logic [15:0]               wr_data,
  input  acc_dec_t                  rd_dec,
  input  logic [15:0]               status_i,
  output logic [15:0]               rd_val,
  output logic [WORD_COUNT*16-1:0]  words_o,
  output logic [BYTE_COUNT*8-1:0]   bytes_o,
  output logic                      inv_a_o,
  output logic                      inv_b_o
);
  localparam logic [15:0] WORD_RST = 16'h0000;
  localparam logic [7:0]  BYTE_RST = 8'h00;

  logic [15:0] word_q [WORD_COUNT];
  logic [7:0]  byte_q [BYTE_COUNT];

  genvar g;
  generate
    for (g = 0; g < WORD_COUNT; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              word_q[g] <= WORD_RST;
        else if (clr_pulse)                      word_q[g] <= WORD_RST;
        else if (wr16_pulse && wr_idx == 8'(g))  word_q[g] <= wr_data;
      end
      assign words_o[16*g +: 16] = word_q[g];
    end
    for (g = 0; g < BYTE_COUNT; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              byte_q[g] <= BYTE_RST;
        else if (clr_pulse)                      byte_q[g] <= BYTE_RST;
        else if (wr8_pulse && wr_idx == 8'(g))   byte_q[g] <= wr_data[7:0];
      end
      assign bytes_o[8*g +: 8] = byte_q[g];
    end
  endgenerate

  // Reply source, left aligned so the engine always shifts from bit 15
  always_comb begin
    rd_val = '0;
    case (rd_dec.kind)
      AK_RD16: begin
        for (int i = 0; i < WORD_COUNT; i++)
          if (rd_dec.idx == 8'(i)) rd_val = word_q[i];
      end
      AK_RD8: begin
        for (int i = 0; i < BYTE_COUNT; i++)
          if (rd_dec.idx == 8'(i)) rd_val = {byte_q[i], 8'h00};
      end
      AK_STAT: rd_val = status_i;
      default: rd_val = '0;
    endcase
  end

  assign inv_a_o = word_q[INV_IDX][7];
  assign inv_b_o = word_q[INV_IDX][15];

  // R4: the clear command empties the whole bank
  assert_clear_empties_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (words_o == '0) && (bytes_o == '0));

  // R1: a word write leaves the byte registers alone
  assert_word_write_spares_bytes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr16_pulse |=> $stable(bytes_o));

endmodule

// File: rtl/serctl_slave.sv
module serctl_slave
  import serctl_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int WORD_COUNT   = 4,
  parameter int BYTE_COUNT   = 2,
  parameter int INV_IDX      = 2,
  parameter int RESET_ADDR   = 8'h01,
  parameter int BYTE_BASE    = 8'h10,
  parameter int BYTE_RD_BASE = 8'h18,
  parameter int WORD_BASE    = 8'h80,
  parameter int WORD_RD_BASE = 8'hC0,
  parameter int STATUS_ADDR  = 8'h94
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     sclk,
  input  logic                     cmd_in,
  input  logic [15:0]              status_i,
  output logic                     reply_o,
  output logic                     reply_oe,
  output logic [WORD_COUNT*16-1:0] words_o,
  output logic [BYTE_COUNT*8-1:0]  bytes_o,
  output logic                     inv_a_o,
  output logic                     inv_b_o
);
  logic        cs_act, cs_end, sclk_rise, sclk_fall, cmd_s;
  logic [7:0]  addr_next;
  acc_dec_t    dec;
  logic [15:0] rd_val;
  logic        wr16_pulse, wr8_pulse, clr_pulse;
  logic [7:0]  wr_idx;
  logic [15:0] wr_data;

  serctl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .cmd_in(cmd_in),
    .cs_act(cs_act), .cs_end(cs_end), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .cmd_s(cmd_s)
  );

  serctl_addr_decode #(
    .RESET_ADDR(RESET_ADDR), .BYTE_BASE(BYTE_BASE), .BYTE_RD_BASE(BYTE_RD_BASE),
    .BYTE_COUNT(BYTE_COUNT), .WORD_BASE(WORD_BASE), .WORD_RD_BASE(WORD_RD_BASE),
    .WORD_COUNT(WORD_COUNT), .STATUS_ADDR(STATUS_ADDR)
  ) u_dec (
    .addr(addr_next), .dec(dec)
  );

  serctl_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_end(cs_end),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cmd_s(cmd_s),
    .addr_next(addr_next), .dec(dec), .rd_val(rd_val),
    .wr16_pulse(wr16_pulse), .wr8_pulse(wr8_pulse), .clr_pulse(clr_pulse),
    .wr_idx(wr_idx), .wr_data(wr_data),
    .reply_bit(reply_o), .reply_oe(reply_oe)
  );

  serctl_regbank #(
    .WORD_COUNT(WORD_COUNT), .BYTE_COUNT(BYTE_COUNT), .INV_IDX(INV_IDX)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr16_pulse(wr16_pulse), .wr8_pulse(wr8_pulse),
    .clr_pulse(clr_pulse), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_dec(dec), .status_i(status_i), .rd_val(rd_val),
    .words_o(words_o), .bytes_o(bytes_o), .inv_a_o(inv_a_o), .inv_b_o(inv_b_o)
  );

  // R3: a commit pulse is always one cycle behind a select release
  assert_commit_follows_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr16_pulse || wr8_pulse || clr_pulse) |-> $past(cs_end));

endmodule

// File: tb/tb_serctl_slave.sv
module tb_serctl_slave;
  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        cmd_in = 1'b0;
  logic [15:0] status_i = 16'h0000;
  logic        reply_o, reply_oe, inv_a_o, inv_b_o;
  logic [63:0] words_o;
  logic [15:0] bytes_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  serctl_slave dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .cmd_in(cmd_in),
    .status_i(status_i), .reply_o(reply_o), .reply_oe(reply_oe),
    .words_o(words_o), .bytes_o(bytes_o), .inv_a_o(inv_a_o), .inv_b_o(inv_b_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One frame: address, nd bits after it (data out, reply sampled before each rise)
  task automatic xfer(input logic [7:0] a, input int nd, input logic [15:0] wd,
                      input bit mid, input logic [15:0] mid_val,
                      output logic [15:0] rd, output logic [31:0] oev);
    rd = '0; oev = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int k = 0; k < 8 + nd; k++) begin
      if (k < 8) cmd_in = a[7-k];
      else begin
        int j;
        j = nd - 1 - (k - 8);
        cmd_in = (j < 16) ? wd[j] : 1'b0;
      end
      repeat (HP) @(negedge clk);
      if (k >= 8) begin
        oev[k-8] = reply_oe;
        if (k - 8 < 16) rd = {rd[14:0], reply_o};
        if (mid && k == 8) status_i = mid_val;
      end
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HP) @(negedge clk);
  endtask

  // {address, data}
  localparam logic [23:0] VEC [6] = '{
    {8'h80, 16'hA55A}, {8'h83, 16'h0001}, {8'h10, 16'h00C3},
    {8'h11, 16'h007E}, {8'h81, 16'h8001}, {8'h82, 16'h0080}
  };

  logic [15:0] rd;
  logic [31:0] oev;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk("R11 words", words_o, 64'h0);
    chk("R11 bytes", {48'h0, bytes_o}, 64'h0);
    chk("R11 oe/inv", {61'h0, reply_oe, inv_a_o, inv_b_o}, 64'h0);

    // Table: write then read back through the serial interface
    for (int v = 0; v < 6; v++) begin
      logic [7:0]  a;
      logic [15:0] d;
      a = VEC[v][23:16];
      d = VEC[v][15:0];
      if (a >= 8'h80) begin
        xfer(a, 16, d, 1'b0, 16'h0, rd, oev);
        chk("R1 word output", {48'h0, words_o[16*(a-8'h80) +: 16]}, {48'h0, d});
        xfer(8'hC0 + (a - 8'h80), 16, 16'h0, 1'b0, 16'h0, rd, oev);
        chk("R5 word readback", {48'h0, rd}, {48'h0, d});
        chk("R8 oe during word reply", {32'h0, oev}, 64'h0000_FFFF);
      end else begin
        xfer(a, 8, d, 1'b0, 16'h0, rd, oev);
        chk("R2 byte output", {56'h0, bytes_o[8*(a-8'h10) +: 8]}, {56'h0, d[7:0]});
        xfer(8'h18 + (a - 8'h10), 8, 16'h0, 1'b0, 16'h0, rd, oev);
        chk("R6 byte readback", {56'h0, rd[7:0]}, {56'h0, d[7:0]});
      end
    end

    // R9 inversion flags: word 2 = 0x0080 then 0x8000
    chk("R9 inv after 0x0080", {62'h0, inv_a_o, inv_b_o}, 64'h2);
    xfer(8'h82, 16, 16'h8000, 1'b0, 16'h0, rd, oev);
    chk("R9 inv after 0x8000", {62'h0, inv_a_o, inv_b_o}, 64'h1);

    // R3 short frame and long frame leave word 1 alone
    xfer(8'h81, 12, 16'h0FFF, 1'b0, 16'h0, rd, oev);
    chk("R3 short frame", {48'h0, words_o[31:16]}, 64'h8001);
    xfer(8'h80, 17, 16'hFFFF, 1'b0, 16'h0, rd, oev);
    chk("R3 long frame", {48'h0, words_o[15:0]}, 64'hA55A);
    xfer(8'hC1, 16, 16'h0, 1'b0, 16'h0, rd, oev);
    chk("R3 readback after cancel", {48'h0, rd}, 64'h8001);

    // R7 status captured at address end
    status_i = 16'h1234;
    xfer(8'h94, 16, 16'h0, 1'b1, 16'hFFFF, rd, oev);
    chk("R7 status snapshot", {48'h0, rd}, 64'h1234);

    // R8 enable drops after the last reply bit and with select high
    xfer(8'hC0, 17, 16'h0, 1'b0, 16'h0, rd, oev);
    chk("R8 oe over 17 clocks", {32'h0, oev}, 64'h0000_FFFF);
    chk("R8 oe idle", {63'h0, reply_oe}, 64'h0);

    // R10 unmapped address
    xfer(8'h40, 16, 16'hFFFF, 1'b0, 16'h0, rd, oev);
    chk("R10 no reply", {32'h0, oev}, 64'h0);
    chk("R10 words kept", words_o, 64'h0001_8000_8001_A55A);
    chk("R10 bytes kept", {48'h0, bytes_o}, 64'h7EC3);

    // R4 clear command: with trailing data ignored, bare form clears
    xfer(8'h01, 8, 16'h00FF, 1'b0, 16'h0, rd, oev);
    chk("R4 clear with data ignored", words_o, 64'h0001_8000_8001_A55A);
    xfer(8'h01, 0, 16'h0, 1'b0, 16'h0, rd, oev);
    chk("R4 words cleared", words_o, 64'h0);
    chk("R4 bytes cleared", {48'h0, bytes_o}, 64'h0);
    xfer(8'hC3, 16, 16'h0, 1'b0, 16'h0, rd, oev);
    chk("R4 readback cleared", {48'h0, rd}, 64'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule